// File: doc/BRIEF.md
# Privilege Guard

This block keeps the privilege state of a processor core and screens every operation and memory write the core issues. A single mode flag marks the core as running in user or supervisor mode. Hardware changes the flag when it sees an event: an interrupt, a trace fault, a fault or a call into the kernel moves the core to supervisor mode, and a return event moves it back to user mode. The block keeps two stack-pointer registers and presents the one that belongs to the current mode, so every entry into supervisor mode also changes stacks.

Each cycle the decoder may present one operation class and the store path may present one write address. In supervisor mode everything passes. In user mode, a supervisor-only operation, or a write that lands in one of the protected address windows, is suppressed: its enable output stays low and a one-cycle fault pulse carries the type-mismatch code to the fault handler. All results are registered, so they appear one clock after the request.

Top module: `priv_guard`

## Requirements
- R1: While reset is held and in the cycle after it, the block shows supervisor mode (`mode_sup_o`=1), the supervisor stack pointer (reset value 0), `op_en_o`=0, `wr_en_o`=0, `fault_valid_o`=0 and `fault_code_o`=0.
- R2: An entry event (`evt_enter_i`) makes `mode_sup_o` 1 after the next clock edge; a return event (`evt_return_i`) alone makes it 0; if both arrive together the entry wins; with neither, the mode holds.
- R3: `sp_o` shows the supervisor stack register when the mode is supervisor and the user stack register when it is user; `sp_we_i` loads `sp_wdata_i` into the register of the mode in force before any event of that cycle, and leaves the other register unchanged.
- R4: In user mode, operation classes 1 (data-cache control), 2 (instruction-cache control), 3 (interrupt enable), 4 (interrupt disable), 5 (interrupt toggle), 6 (halt) and 7 (system control) give `op_en_o`=0 and `fault_valid_o`=1 one cycle later.
- R5: Class 8 (modify process controls) faults in user mode only when `op_mask_nz_i` is 1; with a zero mask it passes with `op_en_o`=1 and no fault.
- R6: In user mode, class 0 (ordinary operation) and classes 9 to 15 pass with `op_en_o`=1 and no fault.
- R7: In supervisor mode every valid operation and write passes (`op_en_o`/`wr_en_o`=1) and `fault_valid_o` stays 0.
- R8: In user mode a write whose address lies inclusively inside any protected window (defaults 0x100..0x3FF, 0xFF000000..0xFF00FFFF, 0xFF010000..0xFF0100FF) gives `wr_en_o`=0 and a fault; addresses outside every window, including one below a base or one above a limit, pass.
- R9: `fault_code_o` is 2 (type mismatch) exactly when `fault_valid_o` is 1 and 0 otherwise; the fault pulse lasts one cycle per offending request and a denied operation and a denied write in the same cycle give one pulse.
- R10: When an event and a request arrive in the same cycle, the request is judged by the mode in force before the event.
- R11: Every output reflects the request of the previous cycle; an invalid request gives a low enable one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_class_i | input | 4 | Decoded operation class |
| op_mask_nz_i | input | 1 | Mask of a modify-process-controls operation is non-zero |
| wr_valid_i | input | 1 | A memory write is presented this cycle |
| wr_addr_i | input | AW | Write address |
| evt_enter_i | input | 1 | Interrupt, trace fault, fault or kernel call |
| evt_return_i | input | 1 | Return to user mode |
| sp_we_i | input | 1 | Load the active stack register |
| sp_wdata_i | input | SPW | Stack-pointer value to load |
| mode_sup_o | output | 1 | 1 = supervisor mode, 0 = user mode |
| sp_o | output | SPW | Stack pointer of the current mode |
| op_en_o | output | 1 | Operation may execute |
| wr_en_o | output | 1 | Write may proceed |
| fault_valid_o | output | 1 | One-cycle fault pulse |
| fault_code_o | output | 3 | Fault type, 2 = type mismatch |

## Verification
A wrong mode flag shows within one cycle of the next request: a privileged operation either passes in user mode or faults in supervisor mode, and `sp_o` presents the wrong bank at once. A stack write landing in the wrong bank stays hidden until the mode next flips, so the bench loads both banks and then crosses modes in both directions to expose it. Window edges are probed one address inside and one outside each limit, since an off-by-one comparison only shows at those addresses.

// File: rtl/priv_pkg.sv
package priv_pkg;

  typedef enum logic [3:0] {
    OPC_PLAIN   = 4'd0,
    OPC_DCACHE  = 4'd1,
    OPC_ICACHE  = 4'd2,
    OPC_INT_ON  = 4'd3,
    OPC_INT_OFF = 4'd4,
    OPC_INT_TGL = 4'd5,
    OPC_HALT    = 4'd6,
    OPC_SYSCTL  = 4'd7,
    OPC_MODPC   = 4'd8
  } op_class_e;

  typedef enum logic [2:0] {
    FLT_NONE          = 3'd0,
    FLT_TYPE_MISMATCH = 3'd2
  } fault_code_e;

  function automatic logic needs_sup(input logic [3:0] cls, input logic mask_nz);
    logic r;
    case (cls)
      OPC_DCACHE, OPC_ICACHE, OPC_INT_ON, OPC_INT_OFF,
      OPC_INT_TGL, OPC_HALT, OPC_SYSCTL: r = 1'b1;
      OPC_MODPC:                         r = mask_nz;
      default:                           r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic enter_i,
  input  logic return_i,
  output logic sup_o
);

  always_ff @(posedge clk) begin
    if (rst)           sup_o <= 1'b1;
    else if (enter_i)  sup_o <= 1'b1;
    else if (return_i) sup_o <= 1'b0;
  end

endmodule

// File: rtl/priv_sp_bank.sv
module priv_sp_bank #(
  parameter int SPW = 32,
  parameter logic [SPW-1:0] SP_RST = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sup_i,
  input  logic           we_i,
  input  logic [SPW-1:0] wdata_i,
  output logic [SPW-1:0] sp_o
);

  localparam int NBANK = 2;

  logic [SPW-1:0] bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                  bank_q[b] <= SP_RST;
      else if (we_i && (sup_i == (b == 1)))     bank_q[b] <= wdata_i;
    end
  end

  assign sp_o = sup_i ? bank_q[1] : bank_q[0];

endmodule

// File: rtl/priv_region_match.sv
module priv_region_match #(
  parameter int AW   = 32,
  parameter int NREG = 3,
  parameter logic [NREG*AW-1:0] BASE  = '0,
  parameter logic [NREG*AW-1:0] LIMIT = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);

  logic [NREG-1:0] hit_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_win
    localparam logic [AW-1:0] LO = BASE[i*AW +: AW];
    localparam logic [AW-1:0] HI = LIMIT[i*AW +: AW];
    assign hit_vec[i] = (addr_i >= LO) && (addr_i <= HI);
  end

  assign hit_o = |hit_vec;

endmodule

// File: rtl/priv_guard.sv
module priv_guard
  import priv_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SPW  = 32,
  parameter int NREG = 3,
  parameter logic [NREG*AW-1:0] WIN_BASE  = {32'hFF01_0000, 32'hFF00_0000, 32'h0000_0100},
  parameter logic [NREG*AW-1:0] WIN_LIMIT = {32'hFF01_00FF, 32'hFF00_FFFF, 32'h0000_03FF},
  parameter logic [SPW-1:0] SP_RST = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid_i,
  input  logic [3:0]     op_class_i,
  input  logic           op_mask_nz_i,
  input  logic           wr_valid_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic           evt_enter_i,
  input  logic           evt_return_i,
  input  logic           sp_we_i,
  input  logic [SPW-1:0] sp_wdata_i,
  output logic           mode_sup_o,
  output logic [SPW-1:0] sp_o,
  output logic           op_en_o,
  output logic           wr_en_o,
  output logic           fault_valid_o,
  output logic [2:0]     fault_code_o
);

  logic sup_q;
  logic win_hit;
  logic deny_op, deny_wr;

  priv_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .enter_i  (evt_enter_i),
    .return_i (evt_return_i),
    .sup_o    (sup_q)
  );

  priv_sp_bank #(.SPW(SPW), .SP_RST(SP_RST)) u_sp (
    .clk     (clk),
    .rst     (rst),
    .sup_i   (sup_q),
    .we_i    (sp_we_i),
    .wdata_i (sp_wdata_i),
    .sp_o    (sp_o)
  );

  priv_region_match #(.AW(AW), .NREG(NREG), .BASE(WIN_BASE), .LIMIT(WIN_LIMIT)) u_win (
    .addr_i (wr_addr_i),
    .hit_o  (win_hit)
  );

  // judged against the mode register, i.e. the mode before any event this cycle
  always_comb begin
    deny_op = op_valid_i && !sup_q && needs_sup(op_class_i, op_mask_nz_i);
    deny_wr = wr_valid_i && !sup_q && win_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_en_o       <= 1'b0;
      wr_en_o       <= 1'b0;
      fault_valid_o <= 1'b0;
      fault_code_o  <= FLT_NONE;
    end else begin
      op_en_o       <= op_valid_i && !deny_op;
      wr_en_o       <= wr_valid_i && !deny_wr;
      fault_valid_o <= deny_op || deny_wr;
      fault_code_o  <= (deny_op || deny_wr) ? FLT_TYPE_MISMATCH : FLT_NONE;
    end
  end

  assign mode_sup_o = sup_q;

endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid_i,
  input logic [3:0] op_class_i,
  input logic       evt_enter_i,
  input logic       evt_return_i,
  input logic       mode_sup_o,
  input logic       op_en_o,
  input logic       wr_en_o,
  input logic       fault_valid_o,
  input logic [2:0] fault_code_o
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode_sup_o && !op_en_o && !wr_en_o && !fault_valid_o));

  p_enter_sup_r2: assert property (@(posedge clk) disable iff (rst)
    evt_enter_i |=> mode_sup_o);

  p_return_user_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_return_i && !evt_enter_i) |=> !mode_sup_o);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!evt_enter_i && !evt_return_i) |=> $stable(mode_sup_o));

  p_halt_user_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !mode_sup_o && op_class_i == 4'd6) |=> (fault_valid_o && !op_en_o));

  p_sup_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_sup_o && op_valid_i) |=> (op_en_o && !fault_valid_o));

  p_code_set_r9: assert property (@(posedge clk) disable iff (rst)
    fault_valid_o |-> (fault_code_o == 3'd2));

  p_code_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !fault_valid_o |-> (fault_code_o == 3'd0));

  p_idle_low_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> !op_en_o);

endmodule

bind priv_guard priv_guard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_valid_i    (op_valid_i),
  .op_class_i    (op_class_i),
  .evt_enter_i   (evt_enter_i),
  .evt_return_i  (evt_return_i),
  .mode_sup_o    (mode_sup_o),
  .op_en_o       (op_en_o),
  .wr_en_o       (wr_en_o),
  .fault_valid_o (fault_valid_o),
  .fault_code_o  (fault_code_o)
);

// File: tb/tb_priv_guard.sv
module tb_priv_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [3:0]  op_class_i = '0;
  logic        op_mask_nz_i = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic        evt_enter_i = 1'b0;
  logic        evt_return_i = 1'b0;
  logic        sp_we_i = 1'b0;
  logic [31:0] sp_wdata_i = '0;
  logic        mode_sup_o;
  logic [31:0] sp_o;
  logic        op_en_o, wr_en_o, fault_valid_o;
  logic [2:0]  fault_code_o;

  always #4 clk = ~clk;  // 125 MHz

  priv_guard dut (.*);

  typedef struct {
    int          due;
    logic        sup;
    logic [31:0] sp;
    logic        oe, we, fv;
    logic [2:0]  fc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic        m_sup = 1'b1;
  logic [31:0] m_usp = '0, m_ssp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic m_priv(input logic [3:0] c, input logic nz);
    return (c >= 4'd1 && c <= 4'd7) || (c == 4'd8 && nz);
  endfunction

  function automatic logic m_prot(input logic [31:0] a);
    return (a >= 32'h100 && a <= 32'h3FF) ||
           (a >= 32'hFF00_0000 && a <= 32'hFF00_FFFF) ||
           (a >= 32'hFF01_0000 && a <= 32'hFF01_00FF);
  endfunction

  task automatic step(input logic ov, input logic [3:0] cls, input logic nz,
                      input logic wv, input logic [31:0] a,
                      input logic en, input logic rt,
                      input logic swe, input logic [31:0] sd, input string tag);
    exp_t e;
    logic pre;
    @(posedge clk); #1;
    op_valid_i = ov; op_class_i = cls; op_mask_nz_i = nz;
    wr_valid_i = wv; wr_addr_i = a; evt_enter_i = en; evt_return_i = rt;
    sp_we_i = swe; sp_wdata_i = sd;
    pre = m_sup;
    e.oe = ov && (pre || !m_priv(cls, nz));
    e.we = wv && (pre || !m_prot(a));
    e.fv = (ov && !pre && m_priv(cls, nz)) || (wv && !pre && m_prot(a));
    e.fc = e.fv ? 3'd2 : 3'd0;
    if (swe) begin
      if (pre) m_ssp = sd; else m_usp = sd;
    end
    m_sup = en ? 1'b1 : (rt ? 1'b0 : pre);
    e.sup = m_sup;
    e.sp  = m_sup ? m_ssp : m_usp;
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 4'd0, 0, 0, 32'h0, 0, 0, 0, 32'h0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (mode_sup_o !== e.sup || sp_o !== e.sp || op_en_o !== e.oe ||
            wr_en_o !== e.we || fault_valid_o !== e.fv || fault_code_o !== e.fc) begin
          errors++;
          $display("FAIL %s: got sup=%b sp=%h oe=%b we=%b fv=%b fc=%0d exp sup=%b sp=%h oe=%b we=%b fv=%b fc=%0d",
                   e.tag, mode_sup_o, sp_o, op_en_o, wr_en_o, fault_valid_o, fault_code_o,
                   e.sup, e.sp, e.oe, e.we, e.fv, e.fc);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 during reset
    if (mode_sup_o !== 1'b1 || sp_o !== 32'h0 || op_en_o !== 1'b0 || wr_en_o !== 1'b0 ||
        fault_valid_o !== 1'b0 || fault_code_o !== 3'd0) begin
      errors++;
      $display("FAIL R1: got sup=%b sp=%h oe=%b we=%b fv=%b fc=%0d exp 1 0 0 0 0 0",
               mode_sup_o, sp_o, op_en_o, wr_en_o, fault_valid_o, fault_code_o);
    end
    @(posedge clk); #1 rst = 1'b0;

    idle("R1 after reset");
    step(0, 4'd0, 0, 0, 0, 0, 0, 1, 32'h0000_1000, "R3 load supervisor stack");
    step(1, 4'd6, 0, 1, 32'h200, 0, 0, 0, 0, "R7 halt and window write in supervisor");
    step(1, 4'd8, 1, 1, 32'hFF00_0010, 0, 0, 0, 0, "R7 modpc nonzero in supervisor");
    step(0, 4'd0, 0, 0, 0, 0, 1, 0, 0, "R2 return to user");
    step(0, 4'd0, 0, 0, 0, 0, 0, 1, 32'h0000_2000, "R3 load user stack");
    idle("R2 user mode holds");
    for (int c = 1; c <= 7; c++)
      step(1, c[3:0], 0, 0, 0, 0, 0, 0, 0, "R4 privileged class in user");
    step(1, 4'd8, 1, 0, 0, 0, 0, 0, 0, "R5 modpc nonzero mask faults");
    step(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, "R5 modpc zero mask passes");
    step(1, 4'd0, 1, 0, 0, 0, 0, 0, 0, "R6 ordinary op passes");
    step(1, 4'd12, 0, 0, 0, 0, 0, 0, 0, "R6 high class passes");
    step(0, 4'd0, 0, 1, 32'h0000_00FF, 0, 0, 0, 0, "R8 below base passes");
    step(0, 4'd0, 0, 1, 32'h0000_0100, 0, 0, 0, 0, "R8 at base blocked");
    step(0, 4'd0, 0, 1, 32'h0000_03FF, 0, 0, 0, 0, "R8 at limit blocked");
    step(0, 4'd0, 0, 1, 32'h0000_0400, 0, 0, 0, 0, "R8 above limit passes");
    step(0, 4'd0, 0, 1, 32'hFF00_FFFF, 0, 0, 0, 0, "R8 register window limit");
    step(0, 4'd0, 0, 1, 32'hFF01_0000, 0, 0, 0, 0, "R8 timer window base");
    step(0, 4'd0, 0, 1, 32'hFF01_0100, 0, 0, 0, 0, "R8 above timer window");
    step(1, 4'd7, 0, 1, 32'hFF00_0004, 0, 0, 0, 0, "R9 op and write denied together");
    idle("R9 pulse ends");
    step(1, 4'd6, 0, 0, 0, 1, 0, 1, 32'h0000_2100, "R10 enter with halt judged as user");
    step(1, 4'd1, 0, 1, 32'h300, 0, 1, 0, 0, "R10 return with op judged as supervisor");
    idle("R3 user stack kept");
    step(0, 4'd0, 0, 0, 0, 1, 1, 0, 0, "R2 enter wins over return");
    step(0, 4'd0, 0, 0, 0, 0, 1, 1, 32'h0000_3000, "R3 write uses mode before return");
    step(0, 4'd0, 0, 0, 0, 1, 0, 0, 0, "R3 supervisor stack after entry");
    step(1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R11 valid op in supervisor");
    idle("R11 idle gives low enable");
    idle("R11 drain");
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule